// File: doc/BRIEF.md
# 32-Pin GPIO Data Port

This block is the data path of a general-purpose I/O port. A simple memory-mapped register bus reads and writes a small set of word registers. The block keeps an output latch that drives the pad output values, and a direction mask that drives the pad output enables. Each pad input passes through a two-stage synchronizer, and software can read the synchronized level.

Software can write the output latch as a whole word. It can also change single bits with no read-modify-write: three write-only strobe addresses force the masked bits to 1, force them to 0, or invert them. Bus writes take effect on the rising clock edge that samples them. Reads are combinational from the address, so read data is valid in the same cycle.

Top module: `pin_bank_io`

## Requirements
- R1: While `rst` is high and after it is released, `pad_out` and `pad_oe` are all zero, and the output data register (offset 0x00) and the direction register (offset 0x14) read zero.
- R2: A write to offset 0x00 replaces the output latch with `wdata`. `pad_out` shows the new value after the clock edge that samples the write. With no write, `pad_out` and `pad_oe` do not change.
- R3: A write to offset 0x04 sets every latch bit whose mask bit is 1 and leaves the other latch bits unchanged.
- R4: A write to offset 0x08 clears every latch bit whose mask bit is 1 and leaves the other latch bits unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose mask bit is 1 and leaves the other latch bits unchanged.
- R6: A write to offset 0x14 loads the direction register. In it, bit n = 1 makes pin n an output. `pad_oe` always equals the direction register, and a read of offset 0x14 returns it.
- R7: A read of offset 0x10 returns `pad_in` delayed by two clock edges. A level driven before edge k becomes visible right after edge k+1. Writes to 0x10 change nothing.
- R8: Reads of the strobe offsets 0x04, 0x08 and 0x0C return zero.
- R9: Reads are combinational from `addr`, so a read of 0x00 returns the current latch in the same cycle. Address bits [1:0] are ignored.
- R10: Offsets 0x18 and 0x1C are unmapped. They read zero, and writes to them change neither the latch nor the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data or bit mask |
| rdata | output | 32 | Read data for `addr`, same cycle |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output latch driving pad values |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
A wrong bit in the output latch or the direction mask shows on `pad_out` or `pad_oe` one edge after the write that caused it. It stays there until a later write overwrites that bit, so a readback of 0x00 or 0x14 catches it right away. A wrong synchronizer depth shows as an input value that appears one edge too early or too late. To expose it, the input check samples at both edges next to the expected one. Decode faults among the strobe addresses show as the wrong bit operation on the masked pins, and they leak into bits that should have stayed unchanged. The bench therefore writes random masks over random latch contents.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int ADDR_W = 5;
  localparam int SEL_W  = ADDR_W - 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 3'd0,
    SEL_SET  = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_TGL  = 3'd3,
    SEL_IN   = 3'd4,
    SEL_DIR  = 3'd5,
    SEL_NA6  = 3'd6,
    SEL_NA7  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_bank_latch.sv
module pin_bank_latch
  import pin_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] out_d;

  always_comb begin
    out_d = out_q;
    if (wr_en) begin
      unique case (sel)
        SEL_DATA: out_d = wdata;
        SEL_SET:  out_d = out_q | wdata;
        SEL_CLR:  out_d = out_q & ~wdata;
        SEL_TGL:  out_d = out_q ^ wdata;
        default:  out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      out_q <= out_d;
      if (wr_en && sel == SEL_DIR) dir_q <= wdata;
    end
  end
endmodule

// File: rtl/pin_bank_rdmux.sv
module pin_bank_rdmux
  import pin_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  reg_sel_e     sel,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] rdata
);
  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = out_q;
      SEL_IN:   rdata = in_q;
      SEL_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_bank_io.sv
module pin_bank_io
  import pin_bank_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe
);
  reg_sel_e     sel;
  logic [W-1:0] out_q, dir_q, in_q;

  assign sel = reg_sel_e'(addr[ADDR_W-1:2]);

  pin_bank_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(in_q)
  );

  pin_bank_latch #(.W(W)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .out_q(out_q), .dir_q(dir_q)
  );

  pin_bank_rdmux #(.W(W)) u_rdmux (
    .sel(sel), .out_q(out_q), .dir_q(dir_q), .in_q(in_q), .rdata(rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk
  import pin_bank_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      rdata,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe
);
  logic [SEL_W-1:0] s;
  logic [1:0]       age_q;
  logic             rst_seen_q;

  assign s = addr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  always @(posedge clk) begin
    if (rst_seen_q === 1'b1) begin
      reset_state_chk: assert (pad_out == '0 && pad_oe == '0);
    end
  end

  // R2
  data_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && s == SEL_DATA) |=> pad_out == $past(wdata));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pad_out) && $stable(pad_oe)));
  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && s == SEL_SET) |=> pad_out == ($past(pad_out) | $past(wdata)));
  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && s == SEL_CLR) |=> pad_out == ($past(pad_out) & ~$past(wdata)));
  // R5
  tgl_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && s == SEL_TGL) |=> pad_out == ($past(pad_out) ^ $past(wdata)));
  // R6
  dir_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && s == SEL_DIR) |=> pad_oe == $past(wdata));
  // R6
  dir_read_chk: assert property (@(posedge clk) disable iff (rst)
    (s == SEL_DIR) |-> rdata == pad_oe);
  // R7
  in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2 && s == SEL_IN) |-> rdata == $past(pad_in, 2));
  // R8
  strobe_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (s == SEL_SET || s == SEL_CLR || s == SEL_TGL) |-> rdata == '0);
  // R9
  data_read_chk: assert property (@(posedge clk) disable iff (rst)
    (s == SEL_DATA) |-> rdata == pad_out);
  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (s == SEL_NA6 || s == SEL_NA7) |-> rdata == '0);
endmodule

bind pin_bank_io pin_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_pin_bank_io.sv
`timescale 1ns/1ps
module sim_pin_bank_io;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] m_out = '0;
  logic [31:0] m_dir = '0;

  always #2.5 clk = ~clk;

  pin_bank_io u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] next_out(input logic [2:0] sel,
                                           input logic [31:0] cur,
                                           input logic [31:0] d);
    case (sel)
      3'd0: return d;
      3'd1: return cur | d;
      3'd2: return cur & ~d;
      3'd3: return cur ^ d;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] read_val(input logic [2:0] sel);
    case (sel)
      3'd0: return m_out;
      3'd5: return m_dir;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_out = next_out(a[4:2], m_out, d);
    if (a[4:2] == 3'd5) m_dir = d;
  endtask

  task automatic rd(input string req, input logic [4:0] a,
                    input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #0.5;
    chk(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wr_en = 1'b1; addr = 5'h00; wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1 pad_out in reset", pad_out, 32'h0);
    chk("R1 pad_oe in reset", pad_oe, 32'h0);
    wr_en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pad_out after reset", pad_out, 32'h0);
    rd("R1 data reg", 5'h00, 32'h0);
    rd("R1 dir reg", 5'h14, 32'h0);

    wr(5'h00, 32'hA5A5_0F0F);
    chk("R2 whole write", pad_out, 32'hA5A5_0F0F);
    rd("R9 data read", 5'h00, 32'hA5A5_0F0F);
    rd("R9 low addr bits ignored", 5'h03, 32'hA5A5_0F0F);
    repeat (3) @(negedge clk);
    chk("R2 hold without write", pad_out, 32'hA5A5_0F0F);
    wr(5'h04, 32'h0000_00F0);
    chk("R3 set", pad_out, 32'hA5A5_0FFF);
    wr(5'h08, 32'hA000_000F);
    chk("R4 clear", pad_out, 32'h05A5_0FF0);
    wr(5'h0C, 32'hFFFF_0000);
    chk("R5 toggle", pad_out, 32'hFA5A_0FF0);
    wr(5'h0C, 32'h0);
    chk("R5 zero mask toggle", pad_out, 32'hFA5A_0FF0);
    wr(5'h14, 32'h1234_5678);
    chk("R6 pad_oe", pad_oe, 32'h1234_5678);
    rd("R6 dir read", 5'h14, 32'h1234_5678);
    rd("R8 set reads zero", 5'h04, 32'h0);
    rd("R8 clear reads zero", 5'h08, 32'h0);
    rd("R8 toggle reads zero", 5'h0C, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'h0);
    wr(5'h10, 32'h0);
    chk("R10 unmapped write latch", pad_out, 32'hFA5A_0FF0);
    chk("R10 unmapped write dir", pad_oe, 32'h1234_5678);
    rd("R7 input write ignored", 5'h00, 32'hFA5A_0FF0);
    rd("R10 unmapped read 0x18", 5'h18, 32'h0);
    rd("R10 unmapped read 0x1C", 5'h1C, 32'h0);

    for (int k = 0; k < 3; k++) begin
      logic [31:0] prev, nv;
      prev = pad_in;
      nv = (k == 0) ? 32'hDEAD_BEEF : $urandom;
      @(negedge clk);
      addr = 5'h10;
      pad_in = nv;
      @(negedge clk);
      chk("R7 not visible after one edge", rdata, prev);
      @(negedge clk);
      chk("R7 visible after two edges", rdata, nv);
    end

    for (int i = 0; i < 300; i++) begin
      logic [2:0]  sel;
      logic [31:0] d;
      sel = 3'($urandom_range(0, 7));
      d = $urandom;
      wr({sel, 2'($urandom_range(0, 3))}, d);
      chk("R2 R3 R4 R5 R10 random pad_out", pad_out, m_out);
      chk("R6 random pad_oe", pad_oe, m_dir);
      if (sel != 3'd4) begin
        rd("R8 R9 random read", {sel, 2'b00}, read_val(sel));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule